// File: doc/BRIEF.md
# UART Receive Frame Queue with Sticky Error Status

This block takes completed characters from a UART receive engine and holds them for a register read port. Each character goes into a small first-in first-out store, together with its framing-error and parity-error markers. A receive-complete output is high while at least one character is waiting. The oldest character is presented on the read data output, and a read strobe removes it.

Three sticky status bits report framing errors, lost characters and parity errors. A bit, once raised, stays high until software writes a one to its mask position. Dropping the receiver enable empties the store and clears every status bit. A mode input selects how a lost character is reported. In immediate mode the overflow bit rises at the clock edge on which the character is lost. In deferred mode the loss is tagged onto the newest stored character, and the overflow bit rises only when that character reaches the read port.

Top module: `rx_frame_queue`

## Requirements
- R1: Stored characters appear on `rd_data` in arrival order. While `rxc` is high, `rd_data` shows the oldest stored character.
- R2: `rxc` is high exactly when at least one character is stored. A cycle with `rd_pop` high removes the oldest character, and `rxc` falls when the last one is removed. A pop on an empty store has no effect.
- R3: Each status bit stays high until a cycle with `st_clr_wr` high and a one in its mask position clears it. The mask positions are bit 0 for framing error, bit 1 for overflow and bit 2 for parity error. Mask zeros leave their bits unchanged.
- R4: While `rx_en` is low, the store is emptied at each clock edge and all three status bits are cleared. Arriving characters and pops are ignored.
- R5: With `ovf_immediate` high, a character that arrives while the store is full and no pop occurs in that cycle sets `st_ovf` at that same clock edge.
- R6: With `ovf_immediate` low, such a lost character tags the newest stored entry. `st_ovf` is set at the clock edge where that entry becomes the oldest, which is the same edge at which it appears on `rd_data`.
- R7: A character that arrives to a full store with no pop in the same cycle is discarded, and the stored characters are kept unchanged. If a pop happens in the same cycle, the arriving character is accepted.
- R8: The framing-error and parity-error markers of a stored character set `st_ferr` and `st_perr` at the clock edge where that character becomes the oldest. They have no effect before then.
- R9: If a set and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable. Low empties the store and clears the status bits |
| ovf_immediate | input | 1 | 1 = report overflow at once, 0 = report it when the tagged entry is read |
| frm_valid | input | 1 | One-cycle strobe from the engine: a character is complete |
| frm_data | input | DATA_W | Received character |
| frm_ferr | input | 1 | Framing error marker for this character |
| frm_perr | input | 1 | Parity error marker for this character |
| rd_pop | input | 1 | Read strobe: removes the oldest character |
| st_clr_wr | input | 1 | Status write-one-to-clear strobe |
| st_clr_mask | input | 3 | Clear mask: bit 0 framing, bit 1 overflow, bit 2 parity |
| rd_data | output | DATA_W | Oldest stored character |
| rxc | output | 1 | Receive complete: at least one character stored |
| st_ferr | output | 1 | Sticky framing error |
| st_ovf | output | 1 | Sticky buffer overflow |
| st_perr | output | 1 | Sticky parity error |

## Verification
A wrong occupancy count shows on the very next read, in one of three ways. A pop can return stale or reordered data on `rd_data`, `rxc` can stay high after the last pop, or a character can be lost without `st_ovf` rising. A head-load event that fires at the wrong time shows within one clock edge as an error bit rising early or late, compared with the character that reaches `rd_data`. The bench keeps its own model of the store and of the status bits, and compares all outputs after every clock cycle. A fault therefore shows up in the cycle in which it first changes a port.

// File: rtl/rxq_pkg.sv
// Package: shared types for the UART receive frame queue.
// Assumes: status bits are indexed by the constants below in every module.
package rxq_pkg;

    // Positions in the status / clear-mask vectors
    localparam int ST_FERR = 0;
    localparam int ST_OVF  = 1;
    localparam int ST_PERR = 2;
    localparam int ST_BITS = 3;

    // Per-entry side flags kept with each stored character
    typedef struct packed {
        logic ovf;   // a later character was lost behind this one (deferred mode)
        logic perr;  // parity error seen on this character
        logic ferr;  // framing error seen on this character
    } rxq_flags_t;

endpackage

// File: rtl/rxq_store.sv
// Module: rxq_store
// Shift-style FIFO of DEPTH characters with per-entry error flags.
// Slot 0 is always the oldest entry. Reports when a new entry becomes
// the head (load_head) with the flags that head will carry, and reports a
// lost character in immediate mode (ovf_now).
// Assumes: DEPTH >= 2; enable low acts as a synchronous flush.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ovf_imm,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_ferr,
    input  logic              push_perr,
    input  logic              pop_req,
    output logic [DATA_W-1:0] head_data,
    output logic              has_data,
    output logic              load_head,
    output rxq_flags_t        load_flags,
    output logic              ovf_now
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DATA_W-1:0] data_n [DEPTH];
    rxq_flags_t        flg_q  [DEPTH];
    rxq_flags_t        flg_n  [DEPTH];
    logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_mid;

    logic full, do_pop, accept, lost;
    rxq_flags_t push_flags;

    // Purpose: qualify the strobes against the occupancy and the enable
    always_comb begin
        full       = (cnt_q == CNT_FULL);
        do_pop     = enable && pop_req && (cnt_q != '0);
        accept     = enable && push_valid && (!full || do_pop);
        lost       = enable && push_valid && full && !do_pop;
        ovf_now    = lost && ovf_imm;
        push_flags = '{ovf: 1'b0, perr: push_perr, ferr: push_ferr};
    end

    // Purpose: next contents of the store after pop, push and overflow tag
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            data_n[i] = data_q[i];
            flg_n[i]  = flg_q[i];
        end
        cnt_mid = cnt_q;
        if (do_pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                data_n[i] = data_q[i + 1];
                flg_n[i]  = flg_q[i + 1];
            end
            data_n[DEPTH-1] = '0;
            flg_n[DEPTH-1]  = '0;
            cnt_mid = cnt_q - CNT_ONE;
        end
        cnt_n = cnt_mid;
        if (accept) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == int'(cnt_mid)) begin
                    data_n[i] = push_data;
                    flg_n[i]  = push_flags;
                end
            end
            cnt_n = cnt_mid + CNT_ONE;
        end
        if (lost && !ovf_imm) begin
            flg_n[DEPTH-1].ovf = 1'b1;
        end
    end

    // Purpose: detect a new head entry and expose the flags it brings
    always_comb begin
        load_head  = (do_pop && (cnt_q > CNT_ONE)) || (accept && (cnt_mid == '0));
        load_flags = flg_n[0];
    end

    // Purpose: register the store; reset or disable empties it
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                data_q[i] <= '0;
                flg_q[i]  <= '0;
            end
        end else begin
            cnt_q <= cnt_n;
            for (int i = 0; i < DEPTH; i++) begin
                data_q[i] <= data_n[i];
                flg_q[i]  <= flg_n[i];
            end
        end
    end

    // Purpose: drive the read-side outputs from the head slot
    always_comb begin
        head_data = data_q[0];
        has_data  = (cnt_q != '0);
    end

    // R1: occupancy never exceeds the depth
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);

    // R2: a character accepted into an empty store makes data available
    assert_push_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enable && push_valid && !has_data |=> has_data);

    // R7: a lost character leaves the head untouched
    assert_full_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> $stable(head_data) && has_data);

    // R4: disable empties the store
    assert_disable_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !has_data);

endmodule

// File: rtl/rxq_sticky.sv
// Module: rxq_sticky
// One sticky status bit: set wins over write-one-to-clear; reset or a
// low enable clears it.
// Assumes: set and clr are single-cycle qualified strobes.
module rxq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set,
    input  logic clr,
    output logic bit_q
);

    // Purpose: hold the bit, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            bit_q <= 1'b0;
        end else if (set) begin
            bit_q <= 1'b1;
        end else if (clr) begin
            bit_q <= 1'b0;
        end
    end

    // R3: a set bit stays set unless cleared
    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q && enable && !clr |=> bit_q);

    // R9: a set in any cycle leaves the bit high, even with a clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        enable && set |=> bit_q);

    // R4: disable clears the bit
    assert_disable_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !bit_q);

endmodule

// File: rtl/rxq_status.sv
// Module: rxq_status
// Bank of sticky error bits. It maps the head-load events and the
// immediate overflow event to set strobes, and the masked write to clear strobes.
// Assumes: bit order given by the rxq_pkg constants.
module rxq_status
    import rxq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               load_head,
    input  rxq_flags_t         load_flags,
    input  logic               ovf_now,
    input  logic               clr_wr,
    input  logic [ST_BITS-1:0] clr_mask,
    output logic [ST_BITS-1:0] status
);

    logic [ST_BITS-1:0] set_vec;
    logic [ST_BITS-1:0] clr_vec;

    // Purpose: build per-bit set and clear strobes
    always_comb begin
        set_vec          = '0;
        set_vec[ST_FERR] = load_head && load_flags.ferr;
        set_vec[ST_PERR] = load_head && load_flags.perr;
        set_vec[ST_OVF]  = ovf_now || (load_head && load_flags.ovf);
        clr_vec          = clr_wr ? clr_mask : '0;
    end

    for (genvar b = 0; b < ST_BITS; b++) begin : g_bit
        rxq_sticky u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (enable),
            .set    (set_vec[b]),
            .clr    (clr_vec[b]),
            .bit_q  (status[b])
        );
    end

endmodule

// File: rtl/rx_frame_queue.sv
// Module: rx_frame_queue (top)
// UART receive frame queue with sticky error status and selectable
// overflow reporting.
// Assumes: frm_valid is a one-cycle strobe per completed character.
module rx_frame_queue
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              ovf_immediate,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_ferr,
    input  logic              frm_perr,
    input  logic              rd_pop,
    input  logic              st_clr_wr,
    input  logic [2:0]        st_clr_mask,
    output logic [DATA_W-1:0] rd_data,
    output logic              rxc,
    output logic              st_ferr,
    output logic              st_ovf,
    output logic              st_perr
);

    logic               load_head;
    rxq_flags_t         load_flags;
    logic               ovf_now;
    logic [ST_BITS-1:0] status;

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_en),
        .ovf_imm    (ovf_immediate),
        .push_valid (frm_valid),
        .push_data  (frm_data),
        .push_ferr  (frm_ferr),
        .push_perr  (frm_perr),
        .pop_req    (rd_pop),
        .head_data  (rd_data),
        .has_data   (rxc),
        .load_head  (load_head),
        .load_flags (load_flags),
        .ovf_now    (ovf_now)
    );

    rxq_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_en),
        .load_head  (load_head),
        .load_flags (load_flags),
        .ovf_now    (ovf_now),
        .clr_wr     (st_clr_wr),
        .clr_mask   (st_clr_mask),
        .status     (status)
    );

    // Purpose: break out the status vector onto named ports
    always_comb begin
        st_ferr = status[ST_FERR];
        st_ovf  = status[ST_OVF];
        st_perr = status[ST_PERR];
    end

    // R5: an immediate-mode loss is visible on the overflow bit at once
    assert_imm_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_now |=> st_ovf);

    // R6: deferred mode never raises overflow without a new head
    assert_deferred_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && !ovf_immediate && !load_head && !st_ovf |=> !st_ovf);

endmodule

// File: tb/rx_frame_queue_tb_top.sv
module rx_frame_queue_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    typedef struct {
        logic [DW-1:0] data;
        logic fe;
        logic pe;
        logic ov;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_en = 1'b0;
    logic          ovf_immediate = 1'b1;
    logic          frm_valid = 1'b0;
    logic [DW-1:0] frm_data = '0;
    logic          frm_ferr = 1'b0;
    logic          frm_perr = 1'b0;
    logic          rd_pop = 1'b0;
    logic          st_clr_wr = 1'b0;
    logic [2:0]    st_clr_mask = '0;
    logic [DW-1:0] rd_data;
    logic          rxc, st_ferr, st_ovf, st_perr;

    exp_item_t exp_q[$];
    logic m_ferr = 1'b0, m_ovf = 1'b0, m_perr = 1'b0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_queue #(.DATA_W(DW), .DEPTH(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ovf_immediate(ovf_immediate),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_ferr(frm_ferr),
        .frm_perr(frm_perr), .rd_pop(rd_pop), .st_clr_wr(st_clr_wr),
        .st_clr_mask(st_clr_mask), .rd_data(rd_data), .rxc(rxc),
        .st_ferr(st_ferr), .st_ovf(st_ovf), .st_perr(st_perr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare all outputs against the model (called after each edge)
    task automatic monitor(input string tag);
        logic exp_rxc;
        exp_rxc = (exp_q.size() != 0);
        check(rxc == exp_rxc, {tag, " rxc R2"}, int'(rxc), int'(exp_rxc));
        if (exp_rxc)
            check(rd_data == exp_q[0].data, {tag, " head R1"}, int'(rd_data), int'(exp_q[0].data));
        check(st_ferr == m_ferr, {tag, " ferr R8/R3"}, int'(st_ferr), int'(m_ferr));
        check(st_ovf  == m_ovf,  {tag, " ovf R5/R6"},  int'(st_ovf),  int'(m_ovf));
        check(st_perr == m_perr, {tag, " perr R8/R3"}, int'(st_perr), int'(m_perr));
    endtask

    // Driver: one cycle of stimulus, model update, then monitor
    task automatic step(input bit v, input logic [DW-1:0] d, input bit fe, input bit pe,
                        input bit pop, input logic [2:0] clr, input string tag);
        bit popped, space, head_new;
        exp_item_t it;
        frm_valid = v; frm_data = d; frm_ferr = fe; frm_perr = pe;
        rd_pop = pop; st_clr_wr = (clr != 3'b000); st_clr_mask = clr;
        head_new = 1'b0;
        if (!rx_en) begin
            exp_q.delete();
            m_ferr = 1'b0; m_ovf = 1'b0; m_perr = 1'b0;
        end else begin
            popped = pop && (exp_q.size() != 0);
            if (popped) begin
                check(rd_data == exp_q[0].data, {tag, " pop data R1"}, int'(rd_data), int'(exp_q[0].data));
                void'(exp_q.pop_front());
                if (exp_q.size() != 0) head_new = 1'b1;
            end
            space = (exp_q.size() < 2);
            if (clr[0]) m_ferr = 1'b0;
            if (clr[1]) m_ovf  = 1'b0;
            if (clr[2]) m_perr = 1'b0;
            if (v && space) begin
                if (exp_q.size() == 0) head_new = 1'b1;
                it.data = d; it.fe = fe; it.pe = pe; it.ov = 1'b0;
                exp_q.push_back(it);
            end else if (v) begin
                if (ovf_immediate) m_ovf = 1'b1;
                else exp_q[exp_q.size()-1].ov = 1'b1;
            end
            if (head_new) begin
                if (exp_q[0].fe) m_ferr = 1'b1;
                if (exp_q[0].pe) m_perr = 1'b1;
                if (exp_q[0].ov) m_ovf  = 1'b1;
            end
        end
        @(negedge clk);
        frm_valid = 1'b0; rd_pop = 1'b0; st_clr_wr = 1'b0; st_clr_mask = '0;
        monitor(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rx_en = 1'b1;
        @(negedge clk);
        monitor("reset R2 R3");

        // R1 R2: push two, read in order
        step(1, 8'hA1, 0, 0, 0, 3'b000, "push A R1");
        step(1, 8'hB2, 1, 0, 0, 3'b000, "push B ferr not head R8");
        check(st_ferr == 1'b0, "R8 ferr before head", int'(st_ferr), 0);
        step(0, 8'h00, 0, 0, 1, 3'b000, "pop A R8 B head");
        check(st_ferr == 1'b1, "R8 ferr at head", int'(st_ferr), 1);
        step(0, 8'h00, 0, 0, 1, 3'b000, "pop B R2");
        step(0, 8'h00, 0, 0, 1, 3'b000, "pop empty R2");
        // R3: zero mask keeps, one clears
        step(0, 8'h00, 0, 0, 0, 3'b110, "clr other bits R3");
        check(st_ferr == 1'b1, "R3 ferr kept", int'(st_ferr), 1);
        step(0, 8'h00, 0, 0, 0, 3'b001, "clr ferr R3");
        // R5 R7: immediate overflow
        ovf_immediate = 1'b1;
        step(1, 8'hC3, 0, 0, 0, 3'b000, "push C");
        step(1, 8'hD4, 0, 0, 0, 3'b000, "push D");
        step(1, 8'hE5, 0, 0, 0, 3'b000, "lost E R5 R7");
        check(st_ovf == 1'b1, "R5 immediate ovf", int'(st_ovf), 1);
        check(rd_data == 8'hC3, "R7 head kept", int'(rd_data), 'hC3);
        step(0, 8'h00, 0, 0, 1, 3'b000, "pop C R7");
        step(0, 8'h00, 0, 0, 1, 3'b000, "pop D R7");
        check(rxc == 1'b0, "R7 E discarded", int'(rxc), 0);
        step(0, 8'h00, 0, 0, 0, 3'b010, "clr ovf R3");
        // R6: deferred overflow
        ovf_immediate = 1'b0;
        step(1, 8'h16, 0, 0, 0, 3'b000, "push F");
        step(1, 8'h27, 0, 0, 0, 3'b000, "push G");
        step(1, 8'h38, 0, 0, 0, 3'b000, "lost H deferred R6");
        check(st_ovf == 1'b0, "R6 ovf not yet", int'(st_ovf), 0);
        step(0, 8'h00, 0, 0, 1, 3'b000, "pop F R6 G head");
        check(st_ovf == 1'b1, "R6 ovf with G", int'(st_ovf), 1);
        step(0, 8'h00, 0, 0, 1, 3'b000, "pop G");
        step(0, 8'h00, 0, 0, 0, 3'b010, "clr ovf R3");
        // R7: full with pop in same cycle accepts
        step(1, 8'h49, 0, 0, 0, 3'b000, "push I");
        step(1, 8'h5A, 0, 0, 0, 3'b000, "push J");
        step(1, 8'h6B, 0, 1, 1, 3'b000, "push K with pop R7");
        check(st_ovf == 1'b0, "R7 no ovf on push+pop", int'(st_ovf), 0);
        step(0, 8'h00, 0, 0, 1, 3'b000, "pop J K head R8");
        check(st_perr == 1'b1, "R8 perr at head", int'(st_perr), 1);
        step(0, 8'h00, 0, 0, 1, 3'b000, "pop K");
        // R9: set beats clear
        step(1, 8'h7C, 1, 0, 0, 3'b001, "set vs clr R9");
        check(st_ferr == 1'b1, "R9 set wins", int'(st_ferr), 1);
        step(1, 8'h8D, 0, 0, 0, 3'b000, "push second");
        // R4: disable flushes and clears, ignores stimulus
        rx_en = 1'b0;
        step(0, 8'h00, 0, 0, 0, 3'b000, "disable R4");
        check(rxc == 1'b0 && st_ferr == 1'b0 && st_perr == 1'b0, "R4 flushed",
              int'({rxc, st_ferr, st_perr}), 0);
        step(1, 8'h9E, 1, 1, 0, 3'b000, "frame while off R4");
        step(0, 8'h00, 0, 0, 1, 3'b000, "pop while off R4");
        rx_en = 1'b1;
        @(negedge clk);
        monitor("re-enable R4");
        check(rxc == 1'b0, "R4 nothing stored", int'(rxc), 0);
        step(1, 8'hAF, 0, 0, 0, 3'b000, "push after enable R1");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule